// File: doc/BRIEF.md
# Substitution-Box Stochastic Random Source

This block produces a fresh pseudo-random word every enabled cycle and turns it into several unipolar stochastic bit streams at once. Two equal-width registers drive the word. One is a maximal-length linear feedback shift register. The other is a mixing state. On each step the shift register advances first. Its new value is XORed into the mixing state. Every 4-bit slice of that XOR result then goes through a fixed 4-in/4-out substitution. The substituted word is rotated left by one bit and becomes both the new mixing state and the published random word.

A single instance feeds several comparators. Each comparator owns one binary level input and emits 1 while the shared random word is strictly below that level. Over a period of 2^WIDTH steps, the density of ones on that stream approximates level / 2^WIDTH. The word width is the base-2 logarithm of the intended stream length, so the default 8-bit width targets 256-cycle streams. Software-free use: a controller loads both registers through the seed port, then holds `enable` high for as many cycles as the stream should last.

The per-cycle action comes from a small decoded operation with three named values:
- OP_HOLD: no load and no enable. Nothing changes.
- OP_STEP: enable without load. The block advances one step.
- OP_SEED: load, with enable ignored. Both registers take the seed values.

The transitions are purely input-driven from any cycle: a load selects OP_SEED, otherwise enable selects OP_STEP, otherwise OP_HOLD.

Top module: `sbox_stream_source`

## Requirements
- R1: While `rst_n` is low, `rand_word` is 0 and the shift register holds 1. With default parameters, the first step after reset therefore yields `rand_word` = 0x72.
- R2: When `seed_load` is high at a clock edge, the mixing state takes `seed_state` and the shift register takes `seed_lfsr`. `rand_word` shows `seed_state` after that edge. `seed_load` has priority over `enable`.
- R3: A `seed_lfsr` value of zero is replaced by 1 when loaded, so the shift register never enters the all-zero lock-up state.
- R4: A step shifts the shift register right by one bit. When the bit shifted out is 1, the feedback mask is XORed in. The mask is 0xB8 at width 8 (0xC, 0xE08, 0xB400 at widths 4, 12, 16).
- R5: A step sets the new state to rotate_left_1(substitute(state XOR next_shift_register)). `rand_word` always equals the mixing state.
- R6: The substitution is applied independently to every 4-bit slice. Input bit 0 of a slice is i0 and bit 3 is i3. It maps 0..F to 6,D,A,2,4,7,E,5,9,B,F,3,8,C,0,1.
- R7: With `seed_load` and `enable` both low, neither `rand_word` nor the shift register changes. A later step continues from the held values.
- R8: `stream_bits[k]` is 1 exactly when `rand_word` < `level_in[k*WIDTH +: WIDTH]`, compared unsigned. This is combinational from the current word.
- R9: The shift register is never zero after reset. A long run of steps interleaved with holds follows the reference sequence without divergence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load both registers from the seed inputs |
| seed_state | input | WIDTH | Seed for the mixing state |
| seed_lfsr | input | WIDTH | Seed for the shift register (zero replaced by 1) |
| enable | input | 1 | Advance one step this cycle |
| level_in | input | STREAMS*WIDTH | Packed binary levels, stream k in slice k |
| rand_word | output | WIDTH | Current random word (mixing state) |
| stream_bits | output | STREAMS | One stochastic bit per stream |

## Verification
The clocked properties assume reset is asserted from time zero. They also assume `seed_load`, `enable` and the seed inputs are settled before each rising edge. This is what makes the one-cycle load and hold relations meaningful. The bench honours this by changing every input one nanosecond after a rising edge and never releasing reset mid-cycle. The bench also issues reset only once, so no property sees a reset in the middle of a run.

// File: rtl/srng_pkg.sv
package srng_pkg;

    // Per-cycle action of the source
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_SEED = 2'd2
    } srng_op_e;

    // Right-shifting Galois feedback masks for maximal-length sequences
    function automatic logic [31:0] galois_mask(input int unsigned width);
        logic [31:0] m;
        case (width)
            4:       m = 32'h0000_000C;
            8:       m = 32'h0000_00B8;
            12:      m = 32'h0000_0E08;
            16:      m = 32'h0000_B400;
            20:      m = 32'h0009_0000;
            24:      m = 32'h00E1_0000;
            28:      m = 32'h0900_0000;
            32:      m = 32'h8020_0003;
            default: m = 32'h0000_0000;
        endcase
        return m;
    endfunction

    // Fixed 4-bit substitution written as sum-of-products per output bit
    function automatic logic [3:0] sbox_nibble(input logic [3:0] n);
        logic i0, i1, i2, i3;
        logic [3:0] o;
        i0 = n[0];
        i1 = n[1];
        i2 = n[2];
        i3 = n[3];
        o[0] = (~i2 & i3) | (i0 & ~i1 & ~i3) | (i0 & i1 & i2);
        o[1] = (i0 & ~i1 & i2 & ~i3) | (i1 & ~i2) | (~i0 & ~i2 & ~i3)
             | (i0 & ~i2 & i3) | (~i0 & i1 & ~i3);
        o[2] = (~i0 & i1 & ~i2 & i3) | (~i1 & ~i3) | (i2 & ~i3)
             | (i0 & ~i1 & i2);
        o[3] = (i0 & ~i1 & ~i2) | (~i0 & i1 & ~i3) | (~i1 & i3)
             | (~i0 & ~i2 & i3);
        return o;
    endfunction

endpackage

// File: rtl/srng_lfsr.sv
module srng_lfsr
    import srng_pkg::*;
#(
    parameter int unsigned          WIDTH     = 8,
    parameter logic [WIDTH-1:0]     RESET_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] lfsr_q,
    output logic [WIDTH-1:0] lfsr_next
);

    localparam logic [WIDTH-1:0] MASK = WIDTH'(galois_mask(WIDTH));

    logic [WIDTH-1:0] seed_safe;

    always_comb begin
        lfsr_next = {1'b0, lfsr_q[WIDTH-1:1]} ^ (lfsr_q[0] ? MASK : '0);
        seed_safe = (seed == '0) ? RESET_VAL : seed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= RESET_VAL;
        end else if (load) begin
            lfsr_q <= seed_safe;
        end else if (step) begin
            lfsr_q <= lfsr_next;
        end
    end

    // R9: lock-up state never reached
    p_lfsr_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R2: a nonzero seed lands unchanged
    p_lfsr_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed != '0) |=> lfsr_q == $past(seed));

    // R3: a zero seed is replaced
    p_lfsr_zero_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == '0) |=> lfsr_q == RESET_VAL);

    // R7: idle cycles leave the register alone
    p_lfsr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(lfsr_q));

endmodule

// File: rtl/srng_mixer.sv
module srng_mixer
    import srng_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] state_q,
    input  logic [WIDTH-1:0] lfsr_next,
    output logic [WIDTH-1:0] state_next
);

    localparam int unsigned SLICES = WIDTH / 4;

    logic [WIDTH-1:0] whitened;
    logic [WIDTH-1:0] substituted;

    assign whitened = state_q ^ lfsr_next;

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        assign substituted[g*4 +: 4] = sbox_nibble(whitened[g*4 +: 4]);
    end

    // rotate left by one bit
    assign state_next = {substituted[WIDTH-2:0], substituted[WIDTH-1]};

endmodule

// File: rtl/srng_compare.sv
module srng_compare #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned STREAMS = 4
) (
    input  logic [WIDTH-1:0]         word,
    input  logic [STREAMS*WIDTH-1:0] levels,
    output logic [STREAMS-1:0]       bits
);

    for (genvar k = 0; k < STREAMS; k++) begin : g_stream
        assign bits[k] = (word < levels[k*WIDTH +: WIDTH]);
    end

endmodule

// File: rtl/sbox_stream_source.sv
module sbox_stream_source
    import srng_pkg::*;
#(
    parameter int unsigned      WIDTH       = 8,
    parameter int unsigned      STREAMS     = 4,
    parameter logic [WIDTH-1:0] STATE_RESET = '0,
    parameter logic [WIDTH-1:0] LFSR_RESET  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     seed_load,
    input  logic [WIDTH-1:0]         seed_state,
    input  logic [WIDTH-1:0]         seed_lfsr,
    input  logic                     enable,
    input  logic [STREAMS*WIDTH-1:0] level_in,
    output logic [WIDTH-1:0]         rand_word,
    output logic [STREAMS-1:0]       stream_bits
);

    srng_op_e         op;
    logic             do_load;
    logic             do_step;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_next;
    logic [WIDTH-1:0] lfsr_q;
    logic [WIDTH-1:0] lfsr_next;

    // Operation decode: load wins over enable
    always_comb begin
        unique case ({seed_load, enable})
            2'b00:   op = OP_HOLD;
            2'b01:   op = OP_STEP;
            2'b10,
            2'b11:   op = OP_SEED;
            default: op = OP_HOLD;
        endcase
    end

    assign do_load = (op == OP_SEED);
    assign do_step = (op == OP_STEP);

    srng_lfsr #(
        .WIDTH     (WIDTH),
        .RESET_VAL (LFSR_RESET)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .step      (do_step),
        .seed      (seed_lfsr),
        .lfsr_q    (lfsr_q),
        .lfsr_next (lfsr_next)
    );

    srng_mixer #(
        .WIDTH (WIDTH)
    ) u_mixer (
        .state_q    (state_q),
        .lfsr_next  (lfsr_next),
        .state_next (state_next)
    );

    // Mixing-state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STATE_RESET;
        end else begin
            unique case (op)
                OP_SEED: state_q <= seed_state;
                OP_STEP: state_q <= state_next;
                default: state_q <= state_q;
            endcase
        end
    end

    assign rand_word = state_q;

    srng_compare #(
        .WIDTH   (WIDTH),
        .STREAMS (STREAMS)
    ) u_compare (
        .word   (rand_word),
        .levels (level_in),
        .bits   (stream_bits)
    );

    // R2: loaded state appears on the output
    p_seed_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> rand_word == $past(seed_state));

    // R7: idle cycles keep the word
    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !enable) |=> $stable(rand_word));

    // R5: a step consumes the shift register's next value
    p_step_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !seed_load) |=> lfsr_q == $past(lfsr_next));

endmodule

// File: tb/sbox_stream_source_tb.sv
`timescale 1ns/1ps
module sbox_stream_source_tb;

    localparam int W = 8;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           seed_load;
    logic [W-1:0]   seed_state;
    logic [W-1:0]   seed_lfsr;
    logic           enable;
    logic [N*W-1:0] level_in;
    logic [W-1:0]   rand_word;
    logic [N-1:0]   stream_bits;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sbox_stream_source u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .seed_load   (seed_load),
        .seed_state  (seed_state),
        .seed_lfsr   (seed_lfsr),
        .enable      (enable),
        .level_in    (level_in),
        .rand_word   (rand_word),
        .stream_bits (stream_bits)
    );

    // Hand-derived substitution table (R6)
    localparam logic [3:0] SUB [16] = '{
        4'h6, 4'hD, 4'hA, 4'h2, 4'h4, 4'h7, 4'hE, 4'h5,
        4'h9, 4'hB, 4'hF, 4'h3, 4'h8, 4'hC, 4'h0, 4'h1
    };

    // {seed_state, seed_lfsr, word after one step}
    localparam logic [23:0] VEC [8] = '{
        {8'h01, 8'h02, 8'hCC},
        {8'h00, 8'h01, 8'h72},
        {8'h1F, 8'h20, 8'hC2},
        {8'h00, 8'hFF, 8'h0B},
        {8'h80, 8'h54, 8'hFF},
        {8'hE9, 8'h0A, 8'h10},
        {8'h3D, 8'h80, 8'hB8},
        {8'h46, 8'h04, 8'h88}
    };

    function automatic logic [W-1:0] ref_lfsr(input logic [W-1:0] l);
        return (l >> 1) ^ (l[0] ? 8'hB8 : 8'h00);
    endfunction

    function automatic logic [W-1:0] ref_mix(input logic [W-1:0] s, input logic [W-1:0] ln);
        logic [W-1:0] x;
        logic [W-1:0] y;
        x = s ^ ln;
        y = {SUB[x[7:4]], SUB[x[3:0]]};
        return {y[6:0], y[7]};
    endfunction

    function automatic logic [N-1:0] ref_bits(input logic [W-1:0] w, input logic [N*W-1:0] lv);
        logic [N-1:0] b;
        for (int k = 0; k < N; k++) b[k] = (w < lv[k*W +: W]);
        return b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [W-1:0] s, input logic [W-1:0] l);
        seed_load = 1'b1; enable = 1'b0; seed_state = s; seed_lfsr = l;
        tick();
        seed_load = 1'b0;
    endtask

    task automatic step();
        enable = 1'b1;
        tick();
        enable = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ms;
        logic [W-1:0] ml;
        rst_n = 1'b0; seed_load = 1'b0; enable = 1'b0;
        seed_state = '0; seed_lfsr = '0;
        level_in = {8'h10, 8'h10, 8'h10, 8'h10};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R8 streams at word 0
        check("R1 reset word", rand_word, 0);
        check("R8 reset streams", stream_bits, 4'hF);
        step();
        check("R1 first step after reset", rand_word, 8'h72);

        // Table walk: R2 load, R4/R5/R6 single step
        for (int i = 0; i < 8; i++) begin
            load(VEC[i][23:16], VEC[i][15:8]);
            check("R2 seed state visible", rand_word, VEC[i][23:16]);
            step();
            check("R5 R6 R4 step result", rand_word, VEC[i][7:0]);
        end

        // R3 zero shift-register seed
        load(8'h00, 8'h00);
        step();
        check("R3 zero seed replaced", rand_word, 8'h72);

        // R2 load priority over enable
        seed_load = 1'b1; enable = 1'b1; seed_state = 8'h5A; seed_lfsr = 8'h33;
        tick();
        seed_load = 1'b0; enable = 1'b0;
        check("R2 load beats enable", rand_word, 8'h5A);

        // R7 hold keeps word and shift register
        load(8'h1F, 8'h20);
        repeat (4) tick();
        check("R7 word held", rand_word, 8'h1F);
        step();
        check("R7 shift register held", rand_word, 8'hC2);

        // R8 strict less-than boundaries
        level_in = {8'hFF, 8'h81, 8'h80, 8'h00};
        load(8'h80, 8'h01);
        check("R8 boundaries at 0x80", stream_bits, 4'b1100);
        load(8'hFF, 8'h01);
        check("R8 full-scale word", stream_bits, 4'b0000);
        load(8'h00, 8'h01);
        check("R8 zero word", stream_bits, 4'b1110);

        // R9 long run against reference, with holds and stream checks
        level_in = {8'h20, 8'hC0, 8'h80, 8'h40};
        ms = 8'hA5; ml = 8'h3C;
        load(ms, ml);
        for (int c = 0; c < 600; c++) begin
            if ((c % 7) == 3) begin
                tick();
            end else begin
                step();
                ml = ref_lfsr(ml);
                ms = ref_mix(ms, ml);
            end
            check("R9 long-run word", rand_word, ms);
            check("R8 long-run streams", stream_bits, ref_bits(ms, level_in));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule